// File: doc/BRIEF.md
# Triangular Code Digit Adder

This block adds two function codes stored in triangular form. A code of order N is a triangle of signed digits. Each digit is addressed by a column k, where k runs from 0 to N-1, and by a row m, where m runs from 0 to k. Column 0 holds one digit and column N-1 holds N digits. Each code also carries a scale exponent. The adder first brings the two exponents to a common value, then adds the two triangles one column per clock.

At each digit position the adder sums the two operand digits and the carries that arrive from the column below. It splits that sum into a legal digit and a carry. The carry leaves a digit in two directions: it goes to the same row and to the row above, both in the next column. When a carry would leave the last column, the adder reports an overflow, which means the caller must truncate and retry.

A one-cycle start request launches an addition. A one-cycle done pulse marks the cycle in which the result, the common exponent and the overflow flag are valid. Those outputs then hold until a later addition begins to replace them.

Top module: `tri_code_adder`

## Requirements
- R1: Each digit is a 3-bit two's-complement field. Digit (m,k) sits in field number k*(k+1)/2+m of the packed triangle, where field f occupies bits [3f+2:3f]. Every digit of a result lies in {-1,0,1}.
- R2: At each position (m,k), with m no greater than k, the sum S is the digit of A plus the digit of B plus every carry that arrives at (m,k). S is split as S = d + 3c, where d is in {-1,0,1}. The digit d is written to the result and c is the carry.
- R3: The carry produced at (m,k) is added both to (m,k+1) and to (m+1,k+1).
- R4: The overflow flag is 1 when at least one carry produced in column N-1 is nonzero, and 0 otherwise. It changes only in the cycle in which done is high.
- R5: The result exponent is the larger of the two input exponents. Let d be the amount by which an operand's exponent falls short of the result exponent. That operand is then read with digit (m,k) taken from its digit (m,k+d) when k+d<N, and as 0 otherwise. A difference of N or more therefore turns the operand into all zeros.
- R6: If start is high while the block is idle, busy goes high after that clock edge. Done is high for exactly one cycle, N clock edges after the start edge. Busy falls at the same edge at which done rises.
- R7: A start request made while busy is high is ignored. The pending result and its exponent are the ones from the accepted request.
- R8: While busy is low, the sum output stays stable.
- R9: After reset, busy, done and the overflow flag are 0, and the sum and the exponent are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request an addition; sampled while idle |
| op_a_i | input | 108 | Operand A digit triangle, packed per R1 |
| op_b_i | input | 108 | Operand B digit triangle, packed per R1 |
| scale_a_i | input | 4 | Operand A scale exponent |
| scale_b_i | input | 4 | Operand B scale exponent |
| busy_o | output | 1 | Addition in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| sum_o | output | 108 | Result digit triangle |
| scale_o | output | 4 | Common scale exponent of the result |
| ovf_o | output | 1 | A carry left the last column |

## Verification
The carry state is a single column vector that is overwritten on every step. A wrong carry therefore damages the digits of the next column, and the damage ripples into every later column. Any such fault shows up in sum_o at the done pulse, N cycles after start. A carry corrupted in the last column shows up only in ovf_o. A fault in the column counter or the sequencing shows up earlier, as a busy or done level on a cycle that disagrees with a model tracked clock by clock. A wrong alignment shows up as digits shifted in the whole result.

// File: rtl/tcadd_pkg.sv
package tcadd_pkg;
  // first field index of column k inside a packed triangle
  function automatic int tri_base(input int k);
    return (k * (k + 1)) / 2;
  endfunction

  // smallest legal digit for radix r
  function automatic int digit_lo(input int r);
    return -(r / 2);
  endfunction
endpackage

// File: rtl/tc_align.sv
module tc_align #(
  parameter int N  = 8,
  parameter int DW = 3,
  parameter int SW = 4,
  localparam int NT = (N * (N + 1)) / 2,
  localparam int TW = NT * DW
) (
  input  logic [TW-1:0] tri_i,
  input  logic [SW-1:0] drop_i,
  output logic [TW-1:0] tri_o
);
  // move every digit down by drop_i columns; rows that no longer fit are lost
  always_comb begin
    tri_o = '0;
    for (int k = 0; k < N; k++) begin
      for (int m = 0; m <= k; m++) begin
        if (int'(drop_i) + k < N) begin
          tri_o[(tcadd_pkg::tri_base(k) + m) * DW +: DW] =
            tri_i[(tcadd_pkg::tri_base(k + int'(drop_i)) + m) * DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/tc_digit_cell.sv
module tc_digit_cell #(
  parameter int R   = 3,
  parameter int DW  = 3,
  parameter int SEW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_same_i,
  input  logic [DW-1:0] c_diag_i,
  output logic [DW-1:0] dig_o,
  output logic [DW-1:0] carry_o
);
  localparam logic signed [SEW-1:0] RS  = SEW'(R);
  localparam logic signed [SEW-1:0] LOS = SEW'(tcadd_pkg::digit_lo(R));

  logic signed [SEW-1:0] s, t, p, d;

  function automatic logic signed [SEW-1:0] sx(input logic [DW-1:0] v);
    return $signed({{(SEW-DW){v[DW-1]}}, v});
  endfunction

  // S = d + R*p with d in [LO, LO+R-1]: p = floor((S-LO)/R)
  always_comb begin
    s = sx(a_i) + sx(b_i) + sx(c_same_i) + sx(c_diag_i);
    t = s - LOS;
    if (t >= 0) p = t / RS;
    else        p = -((-t + RS - SEW'(1)) / RS);
    d = s - RS * p;
    dig_o   = DW'(d);
    carry_o = DW'(p);
  end
endmodule

// File: rtl/tri_code_adder.sv
module tri_code_adder #(
  parameter int R  = 3,
  parameter int N  = 8,
  parameter int DW = 3,
  parameter int SW = 4,
  localparam int NT = (N * (N + 1)) / 2,
  localparam int TW = NT * DW,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [TW-1:0] op_a_i,
  input  logic [TW-1:0] op_b_i,
  input  logic [SW-1:0] scale_a_i,
  input  logic [SW-1:0] scale_b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [TW-1:0] sum_o,
  output logic [SW-1:0] scale_o,
  output logic          ovf_o
);
  // ---------------- alignment ----------------
  logic [SW-1:0] drop_a, drop_b, scale_max;
  logic [TW-1:0] al_a, al_b;

  always_comb begin
    scale_max = (scale_b_i > scale_a_i) ? scale_b_i : scale_a_i;
    drop_a    = scale_max - scale_a_i;
    drop_b    = scale_max - scale_b_i;
  end

  tc_align #(.N(N), .DW(DW), .SW(SW)) u_align_a (.tri_i(op_a_i), .drop_i(drop_a), .tri_o(al_a));
  tc_align #(.N(N), .DW(DW), .SW(SW)) u_align_b (.tri_i(op_b_i), .drop_i(drop_b), .tri_o(al_b));

  // ---------------- state ----------------
  logic          busy_r, done_r, ovf_r;
  logic [CW-1:0] col_r;
  logic [TW-1:0] opa_r, opb_r, sum_r;
  logic [SW-1:0] scale_r;
  logic [DW-1:0] carry_r [N];

  logic          busy_n, done_n, ovf_n;
  logic [CW-1:0] col_n;
  logic [TW-1:0] sum_n;
  logic [DW-1:0] carry_n [N];
  logic          load_en, step_en, last_col;

  // ---------------- current column ----------------
  logic [DW-1:0] a_col [N];
  logic [DW-1:0] b_col [N];
  logic [DW-1:0] c_same [N];
  logic [DW-1:0] c_diag [N];
  logic [DW-1:0] cell_dig [N];
  logic [DW-1:0] cell_cry [N];

  always_comb begin
    for (int m = 0; m < N; m++) begin
      if (m <= int'(col_r)) begin
        a_col[m] = opa_r[(tcadd_pkg::tri_base(int'(col_r)) + m) * DW +: DW];
        b_col[m] = opb_r[(tcadd_pkg::tri_base(int'(col_r)) + m) * DW +: DW];
      end else begin
        a_col[m] = '0;
        b_col[m] = '0;
      end
      c_same[m] = carry_r[m];
      c_diag[m] = (m > 0) ? carry_r[(m > 0) ? m - 1 : 0] : '0;
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_cell
      tc_digit_cell #(.R(R), .DW(DW)) u_cell (
        .a_i      (a_col[g]),
        .b_i      (b_col[g]),
        .c_same_i (c_same[g]),
        .c_diag_i (c_diag[g]),
        .dig_o    (cell_dig[g]),
        .carry_o  (cell_cry[g])
      );
    end
  endgenerate

  // ---------------- next state ----------------
  always_comb begin
    load_en  = !busy_r && start_i;
    step_en  = busy_r;
    last_col = (col_r == CW'(N - 1));
    busy_n   = busy_r;
    done_n   = 1'b0;
    ovf_n    = ovf_r;
    col_n    = col_r;
    sum_n    = sum_r;
    for (int m = 0; m < N; m++) carry_n[m] = carry_r[m];
    if (load_en) begin
      busy_n = 1'b1;
      col_n  = '0;
      for (int m = 0; m < N; m++) carry_n[m] = '0;
    end else if (step_en) begin
      for (int m = 0; m < N; m++) begin
        if (m <= int'(col_r)) begin
          sum_n[(tcadd_pkg::tri_base(int'(col_r)) + m) * DW +: DW] = cell_dig[m];
          carry_n[m] = cell_cry[m];
        end else begin
          carry_n[m] = '0;
        end
      end
      if (last_col) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        ovf_n  = 1'b0;
        for (int m = 0; m < N; m++) if (carry_n[m] != '0) ovf_n = 1'b1;
      end else begin
        col_n = col_r + 1'b1;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      done_r <= 1'b0;
      ovf_r  <= 1'b0;
      col_r  <= '0;
      sum_r  <= '0;
      for (int m = 0; m < N; m++) carry_r[m] <= '0;
    end else begin
      busy_r <= busy_n;
      done_r <= done_n;
      ovf_r  <= ovf_n;
      col_r  <= col_n;
      sum_r  <= sum_n;
      for (int m = 0; m < N; m++) carry_r[m] <= carry_n[m];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_r   <= '0;
      opb_r   <= '0;
      scale_r <= '0;
    end else if (load_en) begin
      opa_r   <= al_a;
      opb_r   <= al_b;
      scale_r <= scale_max;
    end
  end

  assign busy_o  = busy_r;
  assign done_o  = done_r;
  assign sum_o   = sum_r;
  assign scale_o = scale_r;
  assign ovf_o   = ovf_r;
endmodule

// File: rtl/tri_code_adder_chk.sv
module tri_code_adder_chk #(
  parameter int R  = 3,
  parameter int N  = 8,
  parameter int DW = 3,
  parameter int SW = 4,
  localparam int NT = (N * (N + 1)) / 2,
  localparam int TW = NT * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [TW-1:0] sum_o,
  input logic [SW-1:0] scale_o,
  input logic          ovf_o
);
  localparam int LO = tcadd_pkg::digit_lo(R);
  localparam int HI = LO + R - 1;

  function automatic logic all_legal(input logic [TW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int f = 0; f < NT; f++) begin
      if (int'($signed(v[f * DW +: DW])) < LO || int'($signed(v[f * DW +: DW])) > HI) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r1_digits_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> all_legal(sum_o));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  a_r4_ovf_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf_o) |-> done_o);
  a_r8_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(sum_o));
  a_r7_scale_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(scale_o));
endmodule

bind tri_code_adder tri_code_adder_chk #(.R(R), .N(N), .DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .sum_o(sum_o), .scale_o(scale_o), .ovf_o(ovf_o)
);

// File: tb/tri_code_adder_tb.sv
module tri_code_adder_tb;
  localparam int R  = 3;
  localparam int N  = 8;
  localparam int DW = 3;
  localparam int SW = 4;
  localparam int NT = (N * (N + 1)) / 2;
  localparam int TW = NT * DW;
  localparam int LO = -(R / 2);
  localparam int HI = LO + R - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [TW-1:0] opa = '0, opb = '0;
  logic [SW-1:0] sca = '0, scb = '0;
  logic          busy_o, done_o, ovf_o;
  logic [TW-1:0] sum_o;
  logic [SW-1:0] scale_o;

  always #2.5 clk = ~clk;

  tri_code_adder u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_a_i(opa), .op_b_i(opb),
    .scale_a_i(sca), .scale_b_i(scb), .busy_o(busy_o), .done_o(done_o),
    .sum_o(sum_o), .scale_o(scale_o), .ovf_o(ovf_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string what, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int fidx(input int m, input int k);
    return (k * (k + 1)) / 2 + m;
  endfunction

  function automatic int getd(input logic [TW-1:0] v, input int m, input int k);
    return int'($signed(v[fidx(m, k) * DW +: DW]));
  endfunction

  function automatic logic [TW-1:0] putd(input logic [TW-1:0] v, input int m, input int k, input int d);
    logic [TW-1:0] r;
    r = v;
    r[fidx(m, k) * DW +: DW] = DW'(d);
    return r;
  endfunction

  // ---------------- behavioural reference ----------------
  logic [TW-1:0] exp_sum;
  logic [SW-1:0] exp_scale;
  logic          exp_ovf;
  string         cur_tag = "R2";
  string         exp_tag = "R2";

  task automatic ref_add(input logic [TW-1:0] a, input logic [TW-1:0] b,
                         input logic [SW-1:0] sa, input logic [SW-1:0] sb);
    int ga [N][N];
    int gb [N][N];
    int prev [N];
    int nxt [N];
    int top, da, db, s, p;
    top = (sa > sb) ? int'(sa) : int'(sb);
    da = top - int'(sa);
    db = top - int'(sb);
    for (int k = 0; k < N; k++)
      for (int m = 0; m <= k; m++) begin
        ga[m][k] = (k + da < N) ? getd(a, m, k + da) : 0;
        gb[m][k] = (k + db < N) ? getd(b, m, k + db) : 0;
      end
    for (int m = 0; m < N; m++) prev[m] = 0;
    exp_sum = '0;
    for (int k = 0; k < N; k++) begin
      for (int m = 0; m < N; m++) nxt[m] = 0;
      for (int m = 0; m <= k; m++) begin
        s = ga[m][k] + gb[m][k] + prev[m] + ((m > 0) ? prev[m - 1] : 0);
        p = 0;
        while (s > HI) begin s -= R; p++; end
        while (s < LO) begin s += R; p--; end
        exp_sum = putd(exp_sum, m, k, s);
        nxt[m] = p;
      end
      for (int m = 0; m < N; m++) prev[m] = nxt[m];
    end
    exp_ovf = 1'b0;
    for (int m = 0; m < N; m++) if (prev[m] != 0) exp_ovf = 1'b1;
    exp_scale = SW'(top);
  endtask

  // cycle model of the handshake
  logic m_busy, m_done;
  int   m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        m_busy <= 1'b1; m_cnt <= N;
        ref_add(opa, opb, sca, scb);
        exp_tag <= cur_tag;
      end else if (m_busy) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin m_busy <= 1'b0; m_done <= 1'b1; end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy_o === m_busy, "R6 busy level", TW'(busy_o), TW'(m_busy));
      check(done_o === m_done, "R6 done pulse", TW'(done_o), TW'(m_done));
      if (m_done) begin
        check(sum_o === exp_sum, {exp_tag, " sum"}, sum_o, exp_sum);
        check(scale_o === exp_scale, {exp_tag, " R5 scale"}, TW'(scale_o), TW'(exp_scale));
        check(ovf_o === exp_ovf, {exp_tag, " R4 overflow"}, TW'(ovf_o), TW'(exp_ovf));
      end
    end
  end

  task automatic go(input logic [TW-1:0] a, input logic [TW-1:0] b,
                    input logic [SW-1:0] sa, input logic [SW-1:0] sb, input string tag);
    @(negedge clk);
    cur_tag = tag;
    opa = a; opb = b; sca = sa; scb = sb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
  endtask

  function automatic logic [TW-1:0] rnd_tri();
    logic [TW-1:0] v;
    v = '0;
    for (int k = 0; k < N; k++)
      for (int m = 0; m <= k; m++) v = putd(v, m, k, int'($urandom_range(0, R - 1)) + LO);
    return v;
  endfunction

  function automatic logic [TW-1:0] fill(input int d);
    logic [TW-1:0] v;
    v = '0;
    for (int k = 0; k < N; k++)
      for (int m = 0; m <= k; m++) v = putd(v, m, k, d);
    return v;
  endfunction

  initial begin
    logic [TW-1:0] e;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(busy_o === 1'b0, "R9 busy after reset", TW'(busy_o), '0);
    check(done_o === 1'b0, "R9 done after reset", TW'(done_o), '0);
    check(ovf_o === 1'b0, "R9 ovf after reset", TW'(ovf_o), '0);
    check(sum_o === '0, "R9 sum after reset", sum_o, '0);
    check(scale_o === '0, "R9 scale after reset", TW'(scale_o), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    go('0, '0, 4'd0, 4'd0, "R2");
    // R3: 1+1 at (0,0) gives digit -1 and carries into (0,1) and (1,1)
    go(putd('0, 0, 0, 1), putd('0, 0, 0, 1), 4'd0, 4'd0, "R3");
    e = putd(putd(putd('0, 0, 0, -1), 0, 1, 1), 1, 1, 1);
    check(sum_o === e, "R3 two-way carry", sum_o, e);
    // R2: negative sum -2 gives digit 1 and carry -1
    go(putd('0, 1, 3, -1), putd('0, 1, 3, -1), 4'd0, 4'd0, "R2");
    e = putd(putd(putd('0, 1, 3, 1), 1, 4, -1), 2, 4, -1);
    check(sum_o === e, "R2 negative split", sum_o, e);
    // R4: carry leaving last column
    go(putd('0, 0, N - 1, 1), putd('0, 0, N - 1, 1), 4'd0, 4'd0, "R4");
    check(ovf_o === 1'b1, "R4 overflow set", TW'(ovf_o), TW'(1));
    go(putd('0, 2, N - 1, 1), '0, 4'd0, 4'd0, "R4");
    check(ovf_o === 1'b0, "R4 overflow clear", TW'(ovf_o), '0);
    // R1 / R2 all-ones and all-minus-ones
    go(fill(1), fill(1), 4'd2, 4'd2, "R1");
    go(fill(-1), fill(-1), 4'd1, 4'd1, "R1");
    go(fill(1), fill(-1), 4'd0, 4'd0, "R2");
    // R5: A at scale 0 digit (0,1)=1, B zero at scale 1
    go(putd('0, 0, 1, 1), '0, 4'd0, 4'd1, "R5");
    e = putd('0, 0, 0, 1);
    check(sum_o === e, "R5 shifted operand", sum_o, e);
    check(scale_o === 4'd1, "R5 common scale", TW'(scale_o), TW'(1));
    go(fill(1), fill(1), 4'd9, 4'd0, "R5");
    go(rnd_tri(), rnd_tri(), 4'd3, 4'd1, "R5");
    // R7: second start while busy is ignored
    @(negedge clk);
    cur_tag = "R7";
    opa = fill(1); opb = putd('0, 0, 0, 1); sca = 4'd0; scb = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    opa = fill(-1); opb = fill(-1); sca = 4'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    // R8: result holds while idle
    e = sum_o;
    opa = rnd_tri(); opb = rnd_tri();
    repeat (5) @(negedge clk);
    check(sum_o === e, "R8 sum held while idle", sum_o, e);
    // random mix
    for (int i = 0; i < 24; i++)
      go(rnd_tri(), rnd_tri(), SW'($urandom_range(0, 3)), SW'($urandom_range(0, 3)), "R2");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule